// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the slave-side control logic of a three- or four-wire serial EEPROM. It watches the chip-select, serial clock and serial data lines and finds the start bit of each frame. It then collects a two-bit opcode and a ten-bit address field, most significant bit first. It also keeps the lock latch that decides whether commands that modify the array may run.

When a modifying command has been accepted, the block waits for chip-select to drop. It then issues a one-cycle request, with the decoded opcode and address, to an external array model, and runs a self-timed programming interval. If chip-select is raised again after such a write, the serial output reports busy or ready. The output goes back to high impedance as soon as the next start bit is recognised. A low-supply flag cancels any running write and locks the device again.

The serial lines are asynchronous to the free-running system clock, so they are synchronised before edges are detected. The programming interval is a parameterised count of system clocks. The tri-state output is given as a data bit plus an output enable.

Top module: `mw_cmd_frontend`

## Requirements
- R1: The frame begins at the first rising serial-clock edge, with chip-select high, at which data is sampled high. Low bits sampled before that edge are ignored.
- R2: After the start bit, exactly 12 bits are collected MSB first: the opcode (2 bits), then the address (10 bits). On a write request, `wr_op_o` and `wr_addr_o` carry those fields.
- R3: Opcode 00 with address bits [9:8] = 11 unlocks. Opcode 00 with [9:8] = 00 locks. The lower 8 address bits are ignored. Reset leaves the device locked.
- R4: The modifying commands are opcode 01 (write), opcode 11 (erase), opcode 00 with [9:8] = 01 (write all) and opcode 00 with [9:8] = 10 (erase all). While locked they produce no request and no busy.
- R5: An accepted modifying command starts on the falling chip-select edge that follows a complete frame. `write_req_o` is high for exactly one clock. `busy_o` is high for WR_CYCLES clocks starting in the same cycle.
- R6: If chip-select falls before all 12 bits after the start bit have arrived, the frame is dropped and nothing is executed.
- R7: Once a write has started, the output is enabled while chip-select is high. It drives 0 while busy and 1 when ready. At every other time, including after reset, the output enable is low.
- R8: The output enable drops when a new start bit is recognised.
- R9: While `lowv_i` is high, busy is cleared, the device is locked and every command is ignored, including an unlock. After recovery, a fresh unlock is needed before any write.
- R10: A frame whose start bit arrives while busy is never executed, even if busy has cleared by the time chip-select falls.
- R11: Opcode 10 (read) has no effect on the request, busy or the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low power-up reset |
| cs_i | input | 1 | Chip-select, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| lowv_i | input | 1 | Low-supply flag, synchronous to clk |
| do_o | output | 1 | Serial status data (valid when enabled) |
| do_oe_o | output | 1 | Output enable for the serial data line |
| write_req_o | output | 1 | One-cycle request to the array model |
| wr_op_o | output | 2 | Opcode of the requested operation |
| wr_addr_o | output | 10 | Address field of the requested operation |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The assertions assume that `lowv_i` is already synchronous to `clk`. They also assume the serial clock holds each level for longer than the synchroniser latency, so no rising edge is lost. The check on the output enable further assumes the default two-stage synchroniser. The stimulus changes every input on the falling system-clock edge, holds each serial-clock phase for three system clocks, and keeps chip-select and data stable while the serial clock is high. A reference model in the bench replays those inputs through a delay line that matches the synchroniser and compares the outputs on every clock.

// File: rtl/mw_pkg.sv
package mw_pkg;
    // opcode width is fixed by the serial protocol
    localparam int OP_W = 2;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // sub-codes carried in the two top address bits of OPC_EXT
    localparam logic [1:0] SUB_LOCK    = 2'b00;
    localparam logic [1:0] SUB_FILLALL = 2'b01;
    localparam logic [1:0] SUB_CLRALL  = 2'b10;
    localparam logic [1:0] SUB_UNLOCK  = 2'b11;

    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_FULL  = 2'd2
    } phase_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    assign stg_d[0] = din_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl_i,
    input  logic              sk_rise_i,
    input  logic              di_lvl_i,
    output logic              start_o,
    output logic              full_o,
    output logic [OP_W-1:0]   op_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int FRAME_W = OP_W + ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
    } frm_t;

    frm_t d, q;

    always_comb begin
        d       = q;
        start_o = cs_lvl_i && sk_rise_i && (q.ph == PH_HUNT) && di_lvl_i;
        if (!cs_lvl_i) begin
            d.ph  = PH_HUNT;
            d.cnt = '0;
        end else if (sk_rise_i) begin
            unique case (q.ph)
                PH_HUNT: begin
                    if (di_lvl_i) begin
                        d.ph  = PH_SHIFT;
                        d.cnt = '0;
                    end
                end
                PH_SHIFT: begin
                    d.sr  = {q.sr[FRAME_W-2:0], di_lvl_i};
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_W'(FRAME_W - 1)) d.ph = PH_FULL;
                end
                default: d.ph = q.ph;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_HUNT, cnt: '0, sr: '0};
        else        q <= d;
    end

    assign full_o = (q.ph == PH_FULL);
    assign op_o   = q.sr[FRAME_W-1 -: OP_W];
    assign addr_o = q.sr[ADDR_W-1:0];
endmodule

// File: rtl/mw_decode.sv
module mw_decode
    import mw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              unlock_o,
    output logic              lock_o,
    output logic              wclass_o
);
    logic [1:0] sub;

    always_comb begin
        sub      = addr_i[ADDR_W-1 -: 2];
        unlock_o = 1'b0;
        lock_o   = 1'b0;
        wclass_o = 1'b0;
        unique case (op_i)
            OPC_WRITE, OPC_ERASE: wclass_o = 1'b1;
            OPC_EXT: begin
                unique case (sub)
                    SUB_UNLOCK:              unlock_o = 1'b1;
                    SUB_LOCK:                lock_o   = 1'b1;
                    SUB_FILLALL, SUB_CLRALL: wclass_o = 1'b1;
                    default:                 wclass_o = 1'b0;
                endcase
            end
            default: wclass_o = 1'b0;  // OPC_READ: no action here
        endcase
    end
endmodule

// File: rtl/mw_wtimer.sv
module mw_wtimer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic cancel_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cancel_i)                   cnt_d = '0;
        else if (load_i)                cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)           cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_cmd_frontend.sv
module mw_cmd_frontend
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int WR_CYCLES   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    input  logic              lowv_i,
    output logic              do_o,
    output logic              do_oe_o,
    output logic              write_req_o,
    output logic [OP_W-1:0]   wr_op_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              busy_o
);
    localparam int SYNC_W = 3;

    typedef struct packed {
        logic              cs_prev;
        logic              sk_prev;
        logic              wen;
        logic              arm;
        logic              stale;
        logic              req;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t d, q;

    logic [SYNC_W-1:0] sync_w;
    logic              cs_s, sk_s, di_s, sk_rise;
    logic              start_w, full_w, busy_w, load_w;
    logic              unlock_w, lock_w, wclass_w;
    logic              cs_fall, exec_w;
    logic [OP_W-1:0]   f_op;
    logic [ADDR_W-1:0] f_addr;

    mw_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  ({cs_i, sk_i, di_i}),
        .dout_o (sync_w)
    );

    assign cs_s    = sync_w[2];
    assign sk_s    = sync_w[1];
    assign di_s    = sync_w[0];
    assign sk_rise = sk_s & ~q.sk_prev;

    mw_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_lvl_i  (cs_s),
        .sk_rise_i (sk_rise),
        .di_lvl_i  (di_s),
        .start_o   (start_w),
        .full_o    (full_w),
        .op_o      (f_op),
        .addr_o    (f_addr)
    );

    mw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .op_i     (f_op),
        .addr_i   (f_addr),
        .unlock_o (unlock_w),
        .lock_o   (lock_w),
        .wclass_o (wclass_w)
    );

    mw_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .cancel_i (lowv_i),
        .busy_o   (busy_w)
    );

    always_comb begin
        d         = q;
        d.cs_prev = cs_s;
        d.sk_prev = sk_s;
        d.req     = 1'b0;

        cs_fall = q.cs_prev & ~cs_s;
        exec_w  = cs_fall & full_w & ~busy_w & ~q.stale & ~lowv_i;
        load_w  = exec_w & wclass_w & q.wen;

        if (lowv_i)                 d.wen = 1'b0;
        else if (exec_w && unlock_w) d.wen = 1'b1;
        else if (exec_w && lock_w)   d.wen = 1'b0;

        if (load_w) begin
            d.req  = 1'b1;
            d.op   = f_op;
            d.addr = f_addr;
        end

        if (lowv_i)       d.arm = 1'b0;
        else if (load_w)  d.arm = 1'b1;
        else if (start_w) d.arm = 1'b0;

        if (start_w && busy_w) d.stale = 1'b1;
        else if (!cs_s)        d.stale = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign write_req_o = q.req;
    assign wr_op_o     = q.op;
    assign wr_addr_o   = q.addr;
    assign busy_o      = busy_w;
    assign do_oe_o     = q.arm & cs_s;
    assign do_o        = ~busy_w;
endmodule

// File: rtl/mw_cmd_chk.sv
module mw_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_i,
    input logic lowv_i,
    input logic busy_o,
    input logic write_req_o,
    input logic do_oe_o
);
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        write_req_o |=> !write_req_o); // R5

    AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        write_req_o |-> busy_o); // R5

    AST_NO_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        write_req_o |-> !$past(busy_o)); // R10

    AST_LOWV_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        lowv_i |=> (!busy_o && !write_req_o)); // R9

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        do_oe_o |-> $past(cs_i, 2)); // R7
endmodule

bind mw_cmd_frontend mw_cmd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (cs_i),
    .lowv_i      (lowv_i),
    .busy_o      (busy_o),
    .write_req_o (write_req_o),
    .do_oe_o     (do_oe_o)
);

// File: tb/sim_mw_cmd_frontend.sv
module sim_mw_cmd_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int WR         = 200;
    localparam int SK_HALF    = 3;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n, cs, sk, di, lowv;
    logic do_o, do_oe_o, write_req_o, busy_o;
    logic [1:0] wr_op_o;
    logic [9:0] wr_addr_o;

    int compared = 0, mismatched = 0, req_cnt = 0, last_op = 0, last_addr = 0;
    int cyc = 0, base = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_cmd_frontend #(.ADDR_W(10), .WR_CYCLES(WR), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .lowv_i(lowv),
        .do_o(do_o), .do_oe_o(do_oe_o), .write_req_o(write_req_o),
        .wr_op_o(wr_op_o), .wr_addr_o(wr_addr_o), .busy_o(busy_o)
    );

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int h_cs[4], h_sk[4], h_di[4];
    int m_phase, m_bits, m_word, m_wen, m_timer, m_arm, m_stale, m_req, m_op, m_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin h_cs[i] = 0; h_sk[i] = 0; h_di[i] = 0; end
            m_phase = 0; m_bits = 0; m_word = 0; m_wen = 0; m_timer = 0;
            m_arm = 0; m_stale = 0; m_req = 0; m_op = 0; m_addr = 0;
        end else begin
            int c, cp, rise, dbit, fall, startp, was_busy, ex, op, a, sub, wc, nt, nreq;
            for (int i = 3; i > 0; i--) begin
                h_cs[i] = h_cs[i-1]; h_sk[i] = h_sk[i-1]; h_di[i] = h_di[i-1];
            end
            h_cs[0] = cs; h_sk[0] = sk; h_di[0] = di;
            c = h_cs[2]; cp = h_cs[3]; dbit = h_di[2];
            rise = (h_sk[2] == 1 && h_sk[3] == 0);
            fall = (c == 0 && cp == 1);
            startp = (c == 1 && rise && m_phase == 0 && dbit == 1);
            was_busy = (m_timer > 0);
            ex = fall && m_phase == 2 && !was_busy && !m_stale && !lowv;
            op = (m_word >> 10) & 3; a = m_word & 'h3FF; sub = a >> 8;
            wc = (op == 1) || (op == 3) || (op == 0 && (sub == 1 || sub == 2));
            nt = was_busy ? m_timer - 1 : 0;
            nreq = 0;
            if (ex && wc && m_wen) begin nt = WR; nreq = 1; m_op = op; m_addr = a; end
            if (lowv) begin nt = 0; m_wen = 0; end
            else if (ex && op == 0 && sub == 3) m_wen = 1;
            else if (ex && op == 0 && sub == 0) m_wen = 0;
            if (lowv) m_arm = 0; else if (nreq) m_arm = 1; else if (startp) m_arm = 0;
            if (startp && was_busy) m_stale = 1; else if (c == 0) m_stale = 0;
            if (c == 0) begin m_phase = 0; m_bits = 0; end
            else if (rise) begin
                if (m_phase == 0 && dbit == 1) begin m_phase = 1; m_bits = 0; end
                else if (m_phase == 1) begin
                    m_word = ((m_word << 1) | dbit) & 'hFFF;
                    m_bits++;
                    if (m_bits == 12) m_phase = 2;
                end
            end
            m_timer = nt; m_req = nreq;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int m_oe;
            m_oe = (m_arm == 1 && h_cs[1] == 1);
            chk("R5 busy per cycle", busy_o, m_timer > 0);
            chk("R5 write_req per cycle", write_req_o, m_req);
            chk("R7 do_oe per cycle", do_oe_o, m_oe);
            if (m_oe) chk("R7 do level per cycle", do_o, m_timer == 0);
            if (m_req) begin
                chk("R2 op per cycle", wr_op_o, m_op);
                chk("R2 addr per cycle", wr_addr_o, m_addr);
            end
            if (write_req_o) begin req_cnt++; last_op = wr_op_o; last_addr = wr_addr_o; end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wclk(int n); repeat (n) @(negedge clk); endtask
    task automatic sk_bit(logic b); di = b; wclk(SK_HALF); sk = 1; wclk(SK_HALF); sk = 0; endtask
    task automatic cs_on(); cs = 1; wclk(4); endtask
    task automatic cs_off(); sk = 0; di = 0; cs = 0; wclk(8); endtask
    task automatic send_tail(logic [1:0] op, logic [9:0] a);
        for (int i = 1; i >= 0; i--) sk_bit(op[i]);
        for (int i = 9; i >= 0; i--) sk_bit(a[i]);
    endtask
    task automatic send_cmd(logic [1:0] op, logic [9:0] a); sk_bit(1); send_tail(op, a); endtask
    task automatic frame(logic [1:0] op, logic [9:0] a); cs_on(); send_cmd(op, a); cs_off(); endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !done) begin
            done = 1; compared++; mismatched++;
            $display("FAIL R5 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; cs = 0; sk = 0; di = 0; lowv = 0;
        wclk(5); rst_n = 1; wclk(3);
        chk("R7 reset output enable", do_oe_o, 0);
        chk("R5 reset busy", busy_o, 0);
        chk("R5 reset write_req", write_req_o, 0);

        // R3 R4: locked after reset, write ignored
        base = req_cnt; frame(2'b01, 10'h155);
        chk("R4 write while locked", req_cnt - base, 0);
        chk("R4 busy while locked", busy_o, 0);

        // R1: leading zeros, then unlock (R3)
        cs_on(); sk_bit(0); sk_bit(0); sk_bit(0); send_cmd(2'b00, 10'h300); cs_off();

        // R2 R5: write with trailing data bits
        base = req_cnt; cs_on(); send_cmd(2'b01, 10'h2A5);
        for (int i = 0; i < 4; i++) sk_bit(1);
        cs_off();
        chk("R1 R3 write after unlock", req_cnt - base, 1);
        chk("R2 opcode", last_op, 1);
        chk("R2 address", last_addr, 'h2A5);
        chk("R5 busy after start", busy_o, 1);

        // R7: busy shown on DO
        cs_on();
        chk("R7 enable while busy", do_oe_o, 1);
        chk("R7 busy level", do_o, 0);
        // R8: start bit releases DO
        sk_bit(1);
        chk("R8 enable after start bit", do_oe_o, 0);
        // R10: frame begun while busy never runs
        send_tail(2'b11, 10'h0C3);
        wclk(WR);
        chk("R10 busy cleared before cs fall", busy_o, 0);
        base = req_cnt; cs_off();
        chk("R10 stale frame dropped", req_cnt - base, 0);

        // R7: ready level
        base = req_cnt; frame(2'b01, 10'h0F0);
        chk("R5 second write", req_cnt - base, 1);
        wclk(WR + 10);
        cs_on();
        chk("R7 enable when ready", do_oe_o, 1);
        chk("R7 ready level", do_o, 1);
        cs_off();

        // R6: short frame
        base = req_cnt; cs_on();
        sk_bit(1); sk_bit(0); sk_bit(1); sk_bit(1); sk_bit(0);
        cs_off();
        chk("R6 short frame", req_cnt - base, 0);
        chk("R6 busy after short frame", busy_o, 0);

        // R11: read does nothing
        base = req_cnt; frame(2'b10, 10'h3FF);
        chk("R11 read no request", req_cnt - base, 0);
        chk("R11 read no busy", busy_o, 0);

        // R2 R4: erase all through extended opcode
        base = req_cnt; frame(2'b00, 10'h2C3);
        chk("R4 erase-all accepted", req_cnt - base, 1);
        chk("R2 erase-all opcode", last_op, 0);
        chk("R2 erase-all address", last_addr, 'h2C3);
        wclk(WR + 10);

        // R3: lock, then write-all ignored
        frame(2'b00, 10'h07F);
        base = req_cnt; frame(2'b00, 10'h1A5);
        chk("R3 write-all after lock", req_cnt - base, 0);

        // R9: low voltage cancels and relocks
        frame(2'b00, 10'h3C0);
        base = req_cnt; frame(2'b01, 10'h011);
        chk("R9 write before brown-out", req_cnt - base, 1);
        wclk(20); lowv = 1; wclk(3);
        chk("R9 busy cancelled", busy_o, 0);
        frame(2'b00, 10'h3C0);           // unlock during low voltage: ignored
        lowv = 0; wclk(3);
        base = req_cnt; frame(2'b01, 10'h022);
        chk("R9 locked after recovery", req_cnt - base, 0);
        frame(2'b00, 10'h3C0);
        base = req_cnt; frame(2'b01, 10'h033);
        chk("R9 write after fresh unlock", req_cnt - base, 1);
        chk("R9 address after recovery", last_addr, 'h033);
        wclk(WR + 10);

        done = 1;
        summary();
        $finish;
    end
endmodule